// File: doc/BRIEF.md
# Multi-Mode Parallel Port Register Interface

This block is the host-facing register file and address decoder of a PC-style parallel port. A simple I/O bus (address, read strobe, write strobe, 8-bit write data) reaches a small set of registers placed relative to one of three selectable base addresses. The block drives the eight data lines with an output enable, samples them back, holds the control byte that the handshake logic uses, and keeps a small FIFO of tagged bytes for extended-capability traffic.

What a given offset does depends on the mode held in the extended control byte. In standard compatible mode the data register behaves like a plain latch. In bidirectional and extended-capability modes a read returns the sampled lines. In extended-capability mode with the port facing forward, a data-register write becomes a command-tagged FIFO entry. The enhanced-mode address and data ports, and the extended-capability configuration and FIFO offsets, respond only in their own modes. Handshake sequencing, negotiation, DMA and interrupts belong to other blocks. These include the FIFO consumer, which drains through `fq_pop`.

Top module: `ppt_regif`

## Requirements
- R1: `base_sel` 0, 1 and 2 place the base at 378h, 278h and 3BCh. With `base_sel`=3 no offset is decoded. Data (base+0), status (base+1) and control (base+2) are decoded in every mode.
- R2: The mode field is the mode byte's bits [7:5]. The codes are 000 compatible, 001 bidirectional, 100 enhanced and 011 extended-capability, and reset selects 000. The mode byte sits at base+402h and is decoded in every mode. A read returns {bits[7:2] as written, FIFO full, FIFO empty}.
- R3: Offsets base+3 to base+7 are decoded only in enhanced mode and only when the base is 378h or 278h. A write to any of them loads the output latch, and a read returns `pd_in`.
- R4: base+400h reads the constant 10h, and base+401h is a read/write byte that resets to 00h. Both respond only in extended-capability mode.
- R5: A data-register write loads `pd_out` unless the mode is extended-capability with direction forward.
- R6: In compatible mode a data-register read returns the last byte written, not `pd_in`.
- R7: In every mode other than compatible, a data-register read returns `pd_in`. The one exception is extended-capability mode with direction forward.
- R8: In extended-capability mode with control bit 5 = 0, a data-register write pushes {tag 1, byte} and leaves `pd_out` unchanged. A read of the data register there returns FFh and has no side effect.
- R9: `pd_oe` is 1 in compatible mode. In other modes it is the inverse of control bit 5 (1 = input).
- R10: In extended-capability mode, a write to base+400h pushes {tag 0, byte}. Entries leave in write order: `fq_valid` flags a head entry, `fq_dout` = {tag, byte}, and `fq_pop` removes the head.
- R11: The FIFO holds 16 entries. A push while full is dropped, even if a pop happens in the same cycle.
- R12: A read of an undecoded offset returns FFh, and writes to undecoded offsets or to the status register change nothing. The status register reads `status_in`.
- R13: `io_rdata` loads on the clock edge where `io_rd` is high and holds otherwise. It resets to 00h, and a read sees the state from before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_sel | input | 2 | Base address select |
| io_addr | input | 11 | Bus address |
| io_rd | input | 1 | Read strobe |
| io_wr | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| pd_in | input | 8 | Sampled data lines |
| pd_out | output | 8 | Data line drive value |
| pd_oe | output | 1 | Data line output enable |
| status_in | input | 8 | Printer status lines |
| ctl_out | output | 8 | Control register value |
| fq_pop | input | 1 | FIFO consumer pop |
| fq_valid | output | 1 | FIFO head present |
| fq_dout | output | 9 | FIFO head {tag, byte} |

## Verification
Each result appears one rising edge after the strobe that causes it. Read data appears the edge after `io_rd`. Latch, control, FIFO head and output enable change the edge after `io_wr` or `fq_pop`, and none of them depends combinationally on a bus input. The bench drives its strobes on the falling edge and holds them for one cycle. It compares every output against a queue-based reference model at the next falling edge, half a cycle after the edge that updates both. Directed reads compare `io_rdata` in that same slot against hand-computed values.

// File: rtl/ppt_pkg.sv
package ppt_pkg;
   localparam logic [2:0] MODE_SPP = 3'b000;
   localparam logic [2:0] MODE_BIDIR = 3'b001;
   localparam logic [2:0] MODE_ECP = 3'b011;
   localparam logic [2:0] MODE_EPP = 3'b100;

   typedef enum logic [3:0] {
      SEL_NONE,
      SEL_DATA,
      SEL_STAT,
      SEL_CTRL,
      SEL_EADR,
      SEL_EDAT,
      SEL_FIFO,
      SEL_CFGB,
      SEL_MODE
   } sel_e;
endpackage

// File: rtl/ppt_decode.sv
module ppt_decode
   import ppt_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter logic [ADDR_W-1:0] BASE_A = 'h378,
   parameter logic [ADDR_W-1:0] BASE_B = 'h278,
   parameter logic [ADDR_W-1:0] BASE_C = 'h3BC
) (
   input  logic [1:0]        base_sel,
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        mode,
   output sel_e              sel
);
   localparam logic [ADDR_W-1:0] OFF_DATA = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] OFF_CTRL = ADDR_W'(2);
   localparam logic [ADDR_W-1:0] OFF_EADR = ADDR_W'(3);
   localparam logic [ADDR_W-1:0] OFF_ELO  = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFF_EHI  = ADDR_W'(7);
   localparam logic [ADDR_W-1:0] OFF_FIFO = ADDR_W'('h400);
   localparam logic [ADDR_W-1:0] OFF_CFGB = ADDR_W'('h401);
   localparam logic [ADDR_W-1:0] OFF_MODE = ADDR_W'('h402);

   generate
      if (ADDR_W < 11) begin : g_bad_width
         $error("ppt_decode: ADDR_W must reach base+402h");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] off;
   logic              base_ok;
   logic              epp_ok;
   logic              ecp_on;

   always_comb begin
      unique case (base_sel)
         2'd0:    base = BASE_A;
         2'd1:    base = BASE_B;
         2'd2:    base = BASE_C;
         default: base = '0;
      endcase
   end

   assign base_ok = (base_sel != 2'd3);
   assign off     = addr - base;
   assign epp_ok  = (mode == MODE_EPP) && (base_sel != 2'd2);
   assign ecp_on  = (mode == MODE_ECP);

   always_comb begin
      sel = SEL_NONE;
      if (base_ok) begin
         if (off == OFF_DATA)                     sel = SEL_DATA;
         else if (off == OFF_STAT)                sel = SEL_STAT;
         else if (off == OFF_CTRL)                sel = SEL_CTRL;
         else if (off == OFF_EADR && epp_ok)      sel = SEL_EADR;
         else if (off >= OFF_ELO && off <= OFF_EHI && epp_ok)
                                                  sel = SEL_EDAT;
         else if (off == OFF_FIFO && ecp_on)      sel = SEL_FIFO;
         else if (off == OFF_CFGB && ecp_on)      sel = SEL_CFGB;
         else if (off == OFF_MODE)                sel = SEL_MODE;
      end
   end
endmodule

// File: rtl/ppt_fifo.sv
module ppt_fifo #(
   parameter int W     = 9,
   parameter int DEPTH = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int LVL_W = PTR_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [W-1:0]     din,
   input  logic             pop,
   output logic [W-1:0]     dout,
   output logic             empty,
   output logic             full,
   output logic [LVL_W-1:0] level
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("ppt_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]     mem [DEPTH];
   logic [PTR_W-1:0] wr_ptr;
   logic [PTR_W-1:0] rd_ptr;
   logic             push_ok;
   logic             pop_ok;

   assign full    = (level == LVL_W'(DEPTH));
   assign empty   = (level == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wr_ptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         level  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + 1'b1;
         if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
         unique case ({push_ok, pop_ok})
            2'b10:   level <= level + 1'b1;
            2'b01:   level <= level - 1'b1;
            default: level <= level;
         endcase
      end
   end
endmodule

// File: rtl/ppt_rdmux.sv
module ppt_rdmux
   import ppt_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter logic [DATA_W-1:0] CFGA_ID = 'h10
) (
   input  sel_e              sel,
   input  logic              compat,
   input  logic              ecp_fwd,
   input  logic [DATA_W-1:0] data_q,
   input  logic [DATA_W-1:0] pd_in,
   input  logic [DATA_W-1:0] status_in,
   input  logic [DATA_W-1:0] ctl_q,
   input  logic [DATA_W-1:0] cfgb_q,
   input  logic [DATA_W-1:0] mode_rd,
   output logic [DATA_W-1:0] rd_val
);
   localparam logic [DATA_W-1:0] IDLE_VAL = '1;

   always_comb begin
      unique case (sel)
         SEL_DATA: begin
            if (compat)       rd_val = data_q;
            else if (ecp_fwd) rd_val = IDLE_VAL;
            else              rd_val = pd_in;
         end
         SEL_STAT: rd_val = status_in;
         SEL_CTRL: rd_val = ctl_q;
         SEL_EADR,
         SEL_EDAT: rd_val = pd_in;
         SEL_FIFO: rd_val = CFGA_ID;
         SEL_CFGB: rd_val = cfgb_q;
         SEL_MODE: rd_val = mode_rd;
         default:  rd_val = IDLE_VAL;
      endcase
   end
endmodule

// File: rtl/ppt_regif.sv
module ppt_regif
   import ppt_pkg::*;
#(
   parameter int ADDR_W = 11,
   parameter int FIFO_DEPTH = 16,
   parameter logic [ADDR_W-1:0] BASE_A = 'h378,
   parameter logic [ADDR_W-1:0] BASE_B = 'h278,
   parameter logic [ADDR_W-1:0] BASE_C = 'h3BC,
   parameter logic [7:0] CFGA_ID = 8'h10,
   parameter int DIR_BIT = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        base_sel,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_rd,
   input  logic              io_wr,
   input  logic [7:0]        io_wdata,
   output logic [7:0]        io_rdata,
   input  logic [7:0]        pd_in,
   output logic [7:0]        pd_out,
   output logic              pd_oe,
   input  logic [7:0]        status_in,
   output logic [7:0]        ctl_out,
   input  logic              fq_pop,
   output logic              fq_valid,
   output logic [8:0]        fq_dout
);
   localparam int TAG_W = 9;
   localparam int LVL_W = $clog2(FIFO_DEPTH) + 1;

   generate
      if (DIR_BIT < 0 || DIR_BIT > 7) begin : g_bad_dir
         $error("ppt_regif: DIR_BIT outside the control byte");
      end
   endgenerate

   sel_e             sel;
   logic [7:0]       data_q;
   logic [7:0]       ctl_q;
   logic [7:0]       cfgb_q;
   logic [5:0]       mode_hi_q;
   logic [2:0]       mode;
   logic             compat;
   logic             dir_in;
   logic             ecp_fwd;
   logic [7:0]       mode_rd;
   logic [7:0]       rd_val;
   logic             fifo_push;
   logic [TAG_W-1:0] fifo_din;
   logic             fifo_empty;
   logic             fifo_full;
   logic [LVL_W-1:0] fifo_level;
   logic             latch_wr;

   assign mode    = mode_hi_q[5:3];
   assign compat  = (mode == MODE_SPP);
   assign dir_in  = ctl_q[DIR_BIT];
   assign ecp_fwd = (mode == MODE_ECP) && !dir_in;
   assign mode_rd = {mode_hi_q, fifo_full, fifo_empty};

   ppt_decode #(
      .ADDR_W (ADDR_W),
      .BASE_A (BASE_A),
      .BASE_B (BASE_B),
      .BASE_C (BASE_C)
   ) u_dec (
      .base_sel (base_sel),
      .addr     (io_addr),
      .mode     (mode),
      .sel      (sel)
   );

   ppt_rdmux #(
      .DATA_W  (8),
      .CFGA_ID (CFGA_ID)
   ) u_rdmux (
      .sel       (sel),
      .compat    (compat),
      .ecp_fwd   (ecp_fwd),
      .data_q    (data_q),
      .pd_in     (pd_in),
      .status_in (status_in),
      .ctl_q     (ctl_q),
      .cfgb_q    (cfgb_q),
      .mode_rd   (mode_rd),
      .rd_val    (rd_val)
   );

   assign fifo_push = io_wr && ((sel == SEL_DATA && ecp_fwd) || sel == SEL_FIFO);
   assign fifo_din  = {(sel == SEL_DATA), io_wdata};

   ppt_fifo #(
      .W     (TAG_W),
      .DEPTH (FIFO_DEPTH)
   ) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (fifo_push),
      .din   (fifo_din),
      .pop   (fq_pop),
      .dout  (fq_dout),
      .empty (fifo_empty),
      .full  (fifo_full),
      .level (fifo_level)
   );

   assign latch_wr = io_wr && ((sel == SEL_DATA && !ecp_fwd) ||
                               sel == SEL_EADR || sel == SEL_EDAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q    <= '0;
         ctl_q     <= '0;
         cfgb_q    <= '0;
         mode_hi_q <= '0;
         io_rdata  <= '0;
      end else begin
         if (latch_wr)                   data_q    <= io_wdata;
         if (io_wr && sel == SEL_CTRL)   ctl_q     <= io_wdata;
         if (io_wr && sel == SEL_CFGB)   cfgb_q    <= io_wdata;
         if (io_wr && sel == SEL_MODE)   mode_hi_q <= io_wdata[7:2];
         if (io_rd)                      io_rdata  <= rd_val;
      end
   end

   assign pd_out   = data_q;
   assign pd_oe    = compat || !dir_in;
   assign ctl_out  = ctl_q;
   assign fq_valid = !fifo_empty;
endmodule

// File: rtl/ppt_regif_chk.sv
module ppt_regif_chk
   import ppt_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             io_rd,
   input logic             io_wr,
   input logic [7:0]       io_wdata,
   input logic [7:0]       io_rdata,
   input sel_e             sel,
   input logic [2:0]       mode,
   input logic             pd_oe,
   input logic [7:0]       pd_out,
   input logic             fq_pop,
   input logic             full,
   input logic [LVL_W-1:0] level
);
   // R9
   oe_compat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_SPP) |-> pd_oe);

   // R12
   undecoded_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_rd && sel == SEL_NONE) |=> (io_rdata == 8'hFF));

   // R5
   latch_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (io_wr && sel == SEL_DATA && mode == MODE_SPP) |=> (pd_out == $past(io_wdata)));

   // R11
   full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (full && !fq_pop) |=> (level == $past(level)));

   // R11
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      level <= LVL_W'(DEPTH));

   // R13
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |=> $stable(io_rdata));
endmodule

bind ppt_regif ppt_regif_chk #(
   .DEPTH (FIFO_DEPTH),
   .LVL_W (LVL_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .io_rd    (io_rd),
   .io_wr    (io_wr),
   .io_wdata (io_wdata),
   .io_rdata (io_rdata),
   .sel      (sel),
   .mode     (mode),
   .pd_oe    (pd_oe),
   .pd_out   (pd_out),
   .fq_pop   (fq_pop),
   .full     (fifo_full),
   .level    (fifo_level)
);

// File: tb/ppt_regif_test.sv
`timescale 1ns/1ps
module ppt_regif_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  base_sel = 2'd0;
   logic [10:0] io_addr = '0;
   logic        io_rd = 1'b0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic [7:0]  io_rdata;
   logic [7:0]  pd_in = 8'h3C;
   logic [7:0]  pd_out;
   logic        pd_oe;
   logic [7:0]  status_in = 8'h5A;
   logic [7:0]  ctl_out;
   logic        fq_pop = 1'b0;
   logic        fq_valid;
   logic [8:0]  fq_dout;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #10 clk = ~clk;

   ppt_regif uut (
      .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
      .io_rd(io_rd), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .pd_in(pd_in), .pd_out(pd_out), .pd_oe(pd_oe), .status_in(status_in),
      .ctl_out(ctl_out), .fq_pop(fq_pop), .fq_valid(fq_valid), .fq_dout(fq_dout)
   );

   // reference model
   logic [7:0] m_data = 0, m_ctl = 0, m_cfgb = 0, m_mode = 0, m_rdata = 0;
   logic [8:0] m_q[$];

   function automatic int m_dec(logic [10:0] a);
      int b, off, md;
      md = int'(m_mode[7:5]);
      if (base_sel == 2'd3) return 0;
      b = (base_sel == 2'd0) ? 'h378 : (base_sel == 2'd1) ? 'h278 : 'h3BC;
      off = int'(a) - b;
      if (off == 0) return 1;
      if (off == 1) return 2;
      if (off == 2) return 3;
      if (off == 3) return (md == 4 && base_sel != 2'd2) ? 4 : 0;
      if (off >= 4 && off <= 7) return (md == 4 && base_sel != 2'd2) ? 5 : 0;
      if (off == 'h400) return (md == 3) ? 6 : 0;
      if (off == 'h401) return (md == 3) ? 7 : 0;
      if (off == 'h402) return 8;
      return 0;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_data = 0; m_ctl = 0; m_cfgb = 0; m_mode = 0; m_rdata = 0;
         m_q.delete();
      end else begin
         int s;
         bit fwd, full_pre, empty_pre;
         logic [7:0] rv;
         s = m_dec(io_addr);
         fwd = (m_mode[7:5] == 3'd3) && !m_ctl[5];
         full_pre = (m_q.size() == 16);
         empty_pre = (m_q.size() == 0);
         case (s)
            1: rv = (m_mode[7:5] == 3'd0) ? m_data : (fwd ? 8'hFF : pd_in);
            2: rv = status_in;
            3: rv = m_ctl;
            4, 5: rv = pd_in;
            6: rv = 8'h10;
            7: rv = m_cfgb;
            8: rv = {m_mode[7:2], full_pre, empty_pre};
            default: rv = 8'hFF;
         endcase
         if (io_rd) m_rdata = rv;
         if (fq_pop && !empty_pre) void'(m_q.pop_front());
         if (io_wr) begin
            case (s)
               1: if (fwd) begin
                     if (!full_pre) m_q.push_back({1'b1, io_wdata});
                  end else m_data = io_wdata;
               3: m_ctl = io_wdata;
               4, 5: m_data = io_wdata;
               6: if (!full_pre) m_q.push_back({1'b0, io_wdata});
               7: m_cfgb = io_wdata;
               8: m_mode = {io_wdata[7:2], 2'b00};
               default: ;
            endcase
         end
      end
   end

   task automatic chk(bit ok, string req, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n) begin
         chk(io_rdata == m_rdata, "R13 rdata", 16'(io_rdata), 16'(m_rdata));
         chk(pd_out == m_data, "R5 pd_out", 16'(pd_out), 16'(m_data));
         chk(pd_oe == ((m_mode[7:5] == 3'd0) || !m_ctl[5]), "R9 pd_oe",
             16'(pd_oe), 16'((m_mode[7:5] == 3'd0) || !m_ctl[5]));
         chk(ctl_out == m_ctl, "R12 ctl_out", 16'(ctl_out), 16'(m_ctl));
         chk(fq_valid == (m_q.size() != 0), "R10 fq_valid",
             16'(fq_valid), 16'(m_q.size() != 0));
         if (m_q.size() != 0)
            chk(fq_dout == m_q[0], "R10 fq_dout", 16'(fq_dout), 16'(m_q[0]));
      end
   end

   task automatic wr(logic [10:0] a, logic [7:0] d);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
   endtask

   task automatic rd(logic [10:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      io_addr = a; io_rd = 1'b1;
      @(negedge clk);
      io_rd = 1'b0;
      chk(io_rdata == exp, req, 16'(io_rdata), 16'(exp));
   endtask

   task automatic pop1();
      @(negedge clk);
      fq_pop = 1'b1;
      @(negedge clk);
      fq_pop = 1'b0;
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // reset state (R13, R9, R2)
      chk(io_rdata == 8'h00, "R13 reset rdata", 16'(io_rdata), 16'h00);
      chk(pd_oe == 1'b1, "R9 reset oe", 16'(pd_oe), 16'h1);
      chk(fq_valid == 1'b0, "R10 reset empty", 16'(fq_valid), 16'h0);
      rst_n = 1'b1;
      rd(11'h77A, 8'h01, "R2 reset mode byte");
      // compatible mode latch
      wr(11'h378, 8'hA5);
      chk(pd_out == 8'hA5, "R5 latch drive", 16'(pd_out), 16'hA5);
      rd(11'h378, 8'hA5, "R6 compat readback");
      rd(11'h379, 8'h5A, "R12 status read");
      wr(11'h379, 8'h00);
      rd(11'h379, 8'h5A, "R12 status write ignored");
      rd(11'h37B, 8'hFF, "R3 epp offset off in compat");
      wr(11'h37C, 8'h11);
      rd(11'h378, 8'hA5, "R12 undecoded write ignored");
      rd(11'h779, 8'hFF, "R4 cfgB off in compat");
      // base selection
      base_sel = 2'd1;
      rd(11'h278, 8'hA5, "R1 base 278");
      rd(11'h378, 8'hFF, "R1 old base undecoded");
      base_sel = 2'd2;
      rd(11'h3BC, 8'hA5, "R1 base 3BC");
      base_sel = 2'd3;
      rd(11'h378, 8'hFF, "R1 no base");
      rd(11'h77A, 8'hFF, "R1 no base mode byte");
      base_sel = 2'd0;
      // bidirectional mode
      wr(11'h77A, 8'h20);
      rd(11'h77A, 8'h21, "R2 bidir mode readback");
      wr(11'h37A, 8'h20);
      chk(pd_oe == 1'b0, "R9 input direction", 16'(pd_oe), 16'h0);
      rd(11'h378, 8'h3C, "R7 bidir reads pins");
      rd(11'h37A, 8'h20, "R12 control readback");
      wr(11'h37A, 8'h00);
      chk(pd_oe == 1'b1, "R9 output direction", 16'(pd_oe), 16'h1);
      // enhanced mode
      wr(11'h77A, 8'h80);
      pd_in = 8'hC7;
      rd(11'h37B, 8'hC7, "R3 epp address read");
      wr(11'h37D, 8'h66);
      chk(pd_out == 8'h66, "R3 epp data write", 16'(pd_out), 16'h66);
      base_sel = 2'd2;
      rd(11'h3BF, 8'hFF, "R3 epp not at 3BC");
      wr(11'h3C0, 8'h77);
      chk(pd_out == 8'h66, "R3 epp write ignored at 3BC", 16'(pd_out), 16'h66);
      base_sel = 2'd0;
      // extended-capability mode
      wr(11'h77A, 8'h60);
      rd(11'h778, 8'h10, "R4 cfgA constant");
      rd(11'h779, 8'h00, "R4 cfgB reset");
      wr(11'h779, 8'h5C);
      rd(11'h779, 8'h5C, "R4 cfgB write");
      wr(11'h378, 8'hC3);
      chk(pd_out == 8'h66, "R8 fwd write leaves latch", 16'(pd_out), 16'h66);
      chk(fq_dout == 9'h1C3, "R8 command tag", 16'(fq_dout), 16'h1C3);
      rd(11'h378, 8'hFF, "R8 fwd read");
      wr(11'h778, 8'h44);
      rd(11'h77A, 8'h60, "R2 mode byte not empty");
      pop1();
      chk(fq_dout == 9'h044, "R10 data tag order", 16'(fq_dout), 16'h044);
      pop1();
      chk(fq_valid == 1'b0, "R10 drained", 16'(fq_valid), 16'h0);
      for (int i = 0; i < 18; i++) wr(11'h778, 8'(i));
      rd(11'h77A, 8'h62, "R11 full flag");
      wr(11'h378, 8'hEE);
      for (int i = 0; i < 16; i++) begin
         chk(fq_dout == 9'(i), "R11 order after drop", 16'(fq_dout), 16'(i));
         pop1();
      end
      chk(fq_valid == 1'b0, "R11 extra pushes dropped", 16'(fq_valid), 16'h0);
      // reverse direction in extended-capability mode
      wr(11'h37A, 8'h20);
      rd(11'h378, 8'hC7, "R7 ecp reverse reads pins");
      wr(11'h378, 8'h99);
      chk(pd_out == 8'h99, "R5 ecp reverse latch", 16'(pd_out), 16'h99);
      chk(fq_valid == 1'b0, "R8 reverse no push", 16'(fq_valid), 16'h0);
      // back to compatible
      wr(11'h77A, 8'h00);
      chk(pd_oe == 1'b1, "R9 compat ignores direction", 16'(pd_oe), 16'h1);
      rd(11'h778, 8'hFF, "R4 cfgA off in compat");
      wr(11'h778, 8'h11);
      chk(fq_valid == 1'b0, "R12 no push in compat", 16'(fq_valid), 16'h0);
      rd(11'h378, 8'h99, "R6 compat latch");
      repeat (3) @(negedge clk);
      chk(io_rdata == 8'h99, "R13 rdata holds", 16'(io_rdata), 16'h99);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule